// File: doc/BRIEF.md
# Interval Timer Channel

A single channel of a microsecond interval timer. A free-running one-microsecond enable pulse (`tick`) paces a down-counter. Software programs one control word that carries a run bit, a mode bit and a count. Each write of that word reloads the counter at once. When the counter has seen count + 1 ticks the channel raises a level interrupt. In repeat mode it reloads and keeps running. In single mode it drops its own run bit and halts.

A second word at offset 0x4 gives read access to the live count and the pending flag. Writing a one to its bit 30 acknowledges the interrupt. The channel decodes a small byte-offset window, so several channels can be laid side by side at an eight-byte stride by the surrounding address decoder. Reads are combinational from `bus_addr`.

Top module: `itm_channel`

## Requirements
- R1: After reset `irq` is 0, offset 0x0 reads 0 and offset 0x4 reads 0.
- R2: Offset 0x0 holds the control word: bit 31 run, bit 30 repeat mode, bits 28:0 count. It reads back as written. Any write to it loads the counter with the written count in the next cycle and restarts the interval.
- R3: While running, the counter moves only in cycles with `tick` high. A programmed count N raises `irq` at the edge of the (N+1)-th tick after the write, and not before.
- R4: In repeat mode the counter reloads the programmed count on expiry and expires again every N+1 ticks.
- R5: In single mode the channel clears bit 31 of offset 0x0 on expiry, and then raises no further interrupt however many ticks follow.
- R6: Writing 0 to offset 0x0 stops the channel. No expiry follows, and the count at offset 0x4 reads 0.
- R7: `irq` is an active-high level that stays set until a write to offset 0x4 with bit 30 set. A write there with bit 30 clear has no effect.
- R8: If an expiry and an acknowledge write fall in the same cycle, `irq` stays set.
- R9: Offset 0x4 reads the pending flag in bit 31 and the live count in bits 28:0, with all other bits 0.
- R10: The full count 0x1FFFFFFF is accepted and counts down from that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-microsecond count enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset inside the channel window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Level interrupt, active high |

## Verification
On every cycle the assertions check these properties: the count holds in cycles with no tick and no control write; a new interrupt appears only after a tick while running; a pending interrupt survives every cycle with no acknowledge; and an acknowledge with no tick always clears it. Only the bench scenarios can show the exact N+1 interval across a sweep of counts in both modes, the self-clearing run bit in single mode, the restart on rewrite, the collision between expiry and acknowledge, and the full 29-bit count.

// File: rtl/itm_pkg.sv
package itm_pkg;
   localparam int WORD_W   = 32;
   localparam int FIELD_W  = 29;
   localparam int RUN_BIT  = 31;
   localparam int MODE_BIT = 30;
   localparam int ACK_BIT  = 30;
   localparam int PEND_BIT = 31;
   localparam int OFS_CTRL = 0;
   localparam int OFS_STAT = 4;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_STAT = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/itm_regs.sv
module itm_regs
   import itm_pkg::*;
#(
   parameter int CNT_W  = 29,
   parameter int ADDR_W = 3
) (
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   input  logic [WORD_W-1:0] ctrl_q,
   input  logic [CNT_W-1:0]  cnt_q,
   input  logic              pend_q,
   output logic              ctrl_wr,
   output logic              ack_wr,
   output logic [WORD_W-1:0] bus_rdata
);
   reg_sel_e              sel;
   logic [WORD_W-1:0]     stat_word;

   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("itm_regs: ADDR_W must cover an eight-byte window");
      end
   endgenerate

   always_comb begin
      if (bus_addr == ADDR_W'(OFS_CTRL))      sel = SEL_CTRL;
      else if (bus_addr == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
      else                                     sel = SEL_NONE;
   end

   assign ctrl_wr = bus_wr && (sel == SEL_CTRL);
   assign ack_wr  = bus_wr && (sel == SEL_STAT) && bus_wdata[ACK_BIT];

   always_comb begin
      stat_word              = '0;
      stat_word[CNT_W-1:0]   = cnt_q;
      stat_word[PEND_BIT]    = pend_q;
   end

   always_comb begin
      unique case (sel)
         SEL_CTRL: bus_rdata = ctrl_q;
         SEL_STAT: bus_rdata = stat_word;
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/itm_counter.sv
module itm_counter
   import itm_pkg::*;
#(
   parameter int CNT_W = 29
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              ctrl_wr,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] ctrl_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              expire
);
   logic             running;
   logic             repeat_mode;
   logic [CNT_W-1:0] reload;

   assign running     = ctrl_q[RUN_BIT];
   assign repeat_mode = ctrl_q[MODE_BIT];
   assign reload      = ctrl_q[CNT_W-1:0];

   // a control write in the same cycle wins over an expiry
   assign expire = running && tick && !ctrl_wr && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         cnt_q  <= '0;
      end else if (ctrl_wr) begin
         ctrl_q <= wdata;
         cnt_q  <= wdata[CNT_W-1:0];
      end else if (expire) begin
         if (repeat_mode) cnt_q <= reload;
         else             ctrl_q[RUN_BIT] <= 1'b0;
      end else if (running && tick) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/itm_irq.sv
module itm_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic ack_wr,
   output logic pend_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)      pend_q <= 1'b0;
      else if (expire) pend_q <= 1'b1;
      else if (ack_wr) pend_q <= 1'b0;
   end
endmodule

// File: rtl/itm_channel.sv
module itm_channel
   import itm_pkg::*;
#(
   parameter int CNT_W  = 29,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq
);
   generate
      if (CNT_W < 1 || CNT_W > FIELD_W) begin : g_bad_cnt
         $error("itm_channel: CNT_W out of range");
      end
   endgenerate

   logic              ctrl_wr;
   logic              ack_wr;
   logic              expire;
   logic              pend_q;
   logic [WORD_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  cnt_q;

   itm_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .ctrl_q    (ctrl_q),
      .cnt_q     (cnt_q),
      .pend_q    (pend_q),
      .ctrl_wr   (ctrl_wr),
      .ack_wr    (ack_wr),
      .bus_rdata (bus_rdata)
   );

   itm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .ctrl_wr (ctrl_wr),
      .wdata   (bus_wdata),
      .ctrl_q  (ctrl_q),
      .cnt_q   (cnt_q),
      .expire  (expire)
   );

   itm_irq u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .expire (expire),
      .ack_wr (ack_wr),
      .pend_q (pend_q)
   );

   assign irq = pend_q;
endmodule

// File: rtl/itm_channel_chk.sv
module itm_channel_chk #(
   parameter int CNT_W  = 29,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              irq,
   input logic [CNT_W-1:0]  cnt,
   input logic              run
);
   logic ctl_w;
   logic ack_w;
   assign ctl_w = bus_wr && (bus_addr == ADDR_W'(0));
   assign ack_w = bus_wr && (bus_addr == ADDR_W'(4)) && bus_wdata[30];

   // R3: count holds without a tick or control write
   a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !ctl_w) |=> $stable(cnt));

   // R3: a new interrupt follows a tick while running
   a_r3_rise_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(tick && run));

   // R7: the level holds until acknowledged
   a_r7_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack_w) |=> irq);

   // R7: an acknowledge with no tick clears the level
   a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_w && !tick) |=> !irq);

   // R6: a stopped channel neither counts nor raises an interrupt
   a_r6_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !ctl_w) |=> ($stable(cnt) && !$rose(irq)));
endmodule

bind itm_channel itm_channel_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq       (irq),
   .cnt       (cnt_q),
   .run       (ctrl_q[31])
);

// File: tb/tb_itm_channel.sv
module tb_itm_channel;
   localparam int ADDR_W = 3;
   localparam int NMAX   = 10;
   localparam logic [31:0] RUN = 32'h8000_0000;
   localparam logic [31:0] REP = 32'h4000_0000;
   localparam logic [31:0] ACK = 32'h4000_0000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              irq;

   int checks = 0;
   int failures = 0;
   logic [31:0] rd;

   always #5 clk = ~clk;

   itm_channel #(.CNT_W(29), .ADDR_W(ADDR_W)) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one clock cycle, inputs set at a falling edge, released at the next
   task automatic cyc(input logic t, input logic w, input logic [ADDR_W-1:0] a,
                      input logic [31:0] d);
      tick = t; bus_wr = w; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      tick = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      cyc(1'b0, 1'b1, a, d);
   endtask

   // tick followed by one idle cycle
   task automatic tk();
      cyc(1'b1, 1'b0, '0, '0);
      cyc(1'b0, 1'b0, '0, '0);
   endtask

   task automatic rdreg(input logic [ADDR_W-1:0] a, output logic [31:0] v);
      bus_addr = a;
      #1 v = bus_rdata;
   endtask

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      // R1 reset state
      check("R1 irq", {31'd0, irq}, 32'd0);
      rdreg(3'd0, rd); check("R1 ctrl", rd, 32'd0);
      rdreg(3'd4, rd); check("R1 status", rd, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3/R4/R5 sweep over counts in both modes
      for (int m = 0; m < 2; m++) begin
         for (int n = 0; n <= NMAX; n++) begin
            logic [31:0] w;
            w = RUN | (m == 1 ? REP : 32'd0) | 32'(n);
            wr(3'd0, w);
            rdreg(3'd0, rd); check("R2 readback", rd, w);
            rdreg(3'd4, rd); check("R2 load", rd, 32'(n));
            for (int k = 0; k < n; k++) tk();
            check("R3 no early irq", {31'd0, irq}, 32'd0);
            tk();
            check("R3 irq after N+1", {31'd0, irq}, 32'd1);
            rdreg(3'd4, rd);
            check("R9 status", rd, (m == 1) ? (32'h8000_0000 | 32'(n)) : 32'h8000_0000);
            wr(3'd4, ACK);
            check("R7 ack clears", {31'd0, irq}, 32'd0);
            if (m == 1) begin
               for (int k = 0; k < n; k++) tk();
               check("R4 no early repeat", {31'd0, irq}, 32'd0);
               tk();
               check("R4 repeat expiry", {31'd0, irq}, 32'd1);
               wr(3'd4, ACK);
            end else begin
               rdreg(3'd0, rd); check("R5 run bit cleared", rd, 32'(n));
               for (int k = 0; k < n + 3; k++) tk();
               check("R5 no second irq", {31'd0, irq}, 32'd0);
            end
         end
      end

      // R2 rewrite restarts the interval
      wr(3'd0, RUN | 32'd20);
      tk(); tk(); tk();
      rdreg(3'd4, rd); check("R2 counting", rd, 32'd17);
      wr(3'd0, RUN | 32'd7);
      rdreg(3'd4, rd); check("R2 restart", rd, 32'd7);

      // R6 stop by writing zero
      tk(); tk();
      wr(3'd0, 32'd0);
      rdreg(3'd4, rd); check("R6 count zero", rd, 32'd0);
      for (int k = 0; k < 12; k++) tk();
      check("R6 no expiry", {31'd0, irq}, 32'd0);

      // R3 counter ignores idle cycles between ticks
      wr(3'd0, RUN | 32'd3);
      for (int k = 0; k < 6; k++) cyc(1'b0, 1'b0, '0, '0);
      rdreg(3'd4, rd); check("R3 idle no count", rd, 32'd3);

      // R7 ack with bit 30 clear has no effect
      tk(); tk(); tk(); tk();
      check("R7 set", {31'd0, irq}, 32'd1);
      wr(3'd4, ~ACK);
      check("R7 non-ack write ignored", {31'd0, irq}, 32'd1);
      wr(3'd4, ACK);
      check("R7 ack", {31'd0, irq}, 32'd0);

      // R8 expiry and acknowledge in the same cycle
      wr(3'd0, RUN | REP | 32'd1);
      tk(); tk();
      check("R8 first expiry", {31'd0, irq}, 32'd1);
      tk();
      cyc(1'b1, 1'b1, 3'd4, ACK);
      check("R8 collision keeps irq", {31'd0, irq}, 32'd1);
      wr(3'd4, ACK);
      check("R8 later ack", {31'd0, irq}, 32'd0);

      // R10 full count
      wr(3'd0, RUN | 32'h1FFF_FFFF);
      rdreg(3'd4, rd); check("R10 max load", rd, 32'h1FFF_FFFF);
      tk();
      rdreg(3'd4, rd); check("R10 max decrement", rd, 32'h1FFF_FFFE);
      check("R10 no irq", {31'd0, irq}, 32'd0);
      wr(3'd0, 32'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule